// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block sits between a byte-wide host bus and three interval counter channels. The host talks to it through a 2-bit address with separate write and read strobes. Address 3 takes control words. Addresses 0, 1 and 2 are the data ports of the three channels. A control word either configures one channel, freezes one channel's count, or, when its channel field is 3, issues a read-back command. A read-back command can freeze the count, the status byte, or both, for any set of channels at once.

Each channel keeps its own access mode, operating mode and BCD flag. It has two byte-order flip-flops, one for writes and one for reads, so that 16-bit counts can be moved one byte at a time. It also holds a count snapshot and a status snapshot. A snapshot, once taken, is kept until the host has read all of it. The counters are outside this block. They receive a one-cycle load strobe with the 16-bit initial value, their mode and BCD settings, and a gate level. In return they report their live count and their output level.

Top module: `tmr_host_if`

## Requirements
- R1: A control word at address 3 with bits 7:6 below 3 and a nonzero access field (bits 5:4) sets the addressed channel's access mode, its operating mode from bits 3:1, and its BCD flag from bit 0. These values are visible on `mode_o` and `bcd_o` after the write.
- R2: In access mode 1 (low byte only), a data write loads the byte as the count. In access mode 2 (high byte only), it loads the byte shifted left by 8. `load_stb` pulses for one cycle after the write, and `load_val` carries the value.
- R3: In access mode 3 (low then high), the first data write is only held and the second loads {second, first}. Any configuring control word for the channel restarts this sequence at the low byte.
- R4: A control word with access field 0 freezes the addressed channel's live count. Reads then return it as the current access mode dictates: the low byte, the high byte, or the low byte followed by the high byte. After the last byte is read, reads return to the live count.
- R5: A count freeze request (plain or read-back) is ignored while an earlier frozen count has not been fully read.
- R6: A read-back command (bits 7:6 = 3) selects channel 0, 1 and 2 with bits 1, 2 and 3. Bit 5 low freezes their counts, and bit 4 low freezes their status. The status byte is {out level, 0, access[1:0], mode[2:0], bcd}.
- R7: A pending status is returned by the channel's next read ahead of any frozen count, and that read clears it. A status request made while a status is pending is ignored.
- R8: Reads without a snapshot return the live count's low byte in mode 1 and its high byte in mode 2. In mode 3 they alternate low, high, low. A configuring control word restarts the alternation at the low byte.
- R9: `rdata` is registered and updated one cycle after a read strobe. A read of address 3 returns 0xFF.
- R10: During reset and in the first cycle after it, every channel is in mode 3 with access mode 3. `load_stb` is high on all channels with `load_val` 0, which the counters read as 65536. `gate_o` is 1 for channels 0 and 1 and 0 for channel 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register address (3 = control) |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| cnt_live | input | NCH*16 | Live count from each counter |
| out_lvl | input | NCH | Output level of each counter |
| gate_req | input | NCH | Requested gate level for each counter |
| load_stb | output | NCH | One-cycle load pulse per counter |
| load_val | output | NCH*16 | Initial value per counter (0 = 65536) |
| mode_o | output | NCH*3 | Operating mode per counter |
| bcd_o | output | NCH | BCD flag per counter |
| gate_o | output | NCH | Registered gate level per counter |

## Verification
The hardest situation to reach is the overlap of snapshots. A status and a count are frozen together by one read-back command, and a second freeze request then arrives while half of a word-mode count is still unread. The live count has changed in the meantime. The stimulus first issues a read-back command for all channels and then drains each channel in a different order. Separately, it takes a word-mode snapshot, changes the live count, reads one byte and repeats the freeze command. The byte that follows shows whether the old snapshot survived.

// File: rtl/tmr_host_pkg.sv
package tmr_host_pkg;

  // access field of a control word; the same code marks a pending snapshot
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_LO   = 2'd1,
    ACC_HI   = 2'd2,
    ACC_WORD = 2'd3
  } acc_e;

  localparam logic [1:0] CTRL_ADDR = 2'd3;
  localparam logic [1:0] RB_CODE   = 2'd3;
  localparam logic [2:0] MODE_RST  = 3'd3;

  function automatic logic [7:0] status_byte(input logic out_l, input acc_e acc,
                                             input logic [2:0] mode, input logic bcd);
    return {out_l, 1'b0, acc, mode, bcd};
  endfunction

  function automatic logic [15:0] compose_count(input acc_e acc, input logic [7:0] low_held,
                                                input logic [7:0] byte_in);
    logic [15:0] v;
    case (acc)
      ACC_LO:   v = {8'h00, byte_in};
      ACC_HI:   v = {byte_in, 8'h00};
      default:  v = {byte_in, low_held};
    endcase
    return v;
  endfunction

  function automatic logic [7:0] pick_byte(input logic [15:0] v, input logic hi);
    return hi ? v[15:8] : v[7:0];
  endfunction

endpackage

// File: rtl/tmr_ctrl_decode.sv
module tmr_ctrl_decode
  import tmr_host_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic           wr_en,
  input  logic [1:0]     addr,
  input  logic [7:0]     wdata,
  output logic [NCH-1:0] cfg_we,
  output logic [NCH-1:0] data_we,
  output logic [NCH-1:0] cnt_frz_req,
  output logic [NCH-1:0] sts_frz_req,
  output acc_e           cw_acc,
  output logic [2:0]     cw_mode,
  output logic           cw_bcd
);
  logic       ctl_wr;
  logic       is_rb;
  logic [1:0] chan_f;

  assign ctl_wr  = wr_en && (addr == CTRL_ADDR);
  assign chan_f  = wdata[7:6];
  assign is_rb   = (chan_f == RB_CODE);
  assign cw_acc  = acc_e'(wdata[5:4]);
  assign cw_mode = wdata[3:1];
  assign cw_bcd  = wdata[0];

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    logic hit_ch;
    assign hit_ch         = ctl_wr && !is_rb && (chan_f == 2'(i));
    assign data_we[i]     = wr_en && (addr == 2'(i));
    assign cfg_we[i]      = hit_ch && (cw_acc != ACC_NONE);
    assign cnt_frz_req[i] = (hit_ch && (cw_acc == ACC_NONE)) ||
                            (ctl_wr && is_rb && wdata[i+1] && !wdata[5]);
    assign sts_frz_req[i] = ctl_wr && is_rb && wdata[i+1] && !wdata[4];
  end

endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
  import tmr_host_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  acc_e        cw_acc,
  input  logic [2:0]  cw_mode,
  input  logic        cw_bcd,
  input  logic        data_we,
  input  logic [7:0]  wbyte,
  input  logic        cnt_frz_req,
  input  logic        sts_frz_req,
  input  logic        rd_hit,
  input  logic [15:0] cnt_live,
  input  logic        out_lvl,
  output logic [7:0]  rd_byte,
  output logic        load_stb,
  output logic [15:0] load_val,
  output logic [2:0]  mode,
  output logic        bcd,
  output logic        sts_pend,
  output acc_e        cnt_pend,
  output logic [15:0] cnt_snap
);
  acc_e        acc_q;
  logic        wseq_hi_q;
  logic        rseq_hi_q;
  logic [7:0]  low_held_q;
  logic [7:0]  sts_q;
  logic        load_now;

  assign load_now = data_we && ((acc_q != ACC_WORD) || wseq_hi_q);

  always_comb begin
    if (sts_pend)
      rd_byte = sts_q;
    else if (cnt_pend != ACC_NONE)
      rd_byte = pick_byte(cnt_snap, cnt_pend == ACC_HI);
    else begin
      case (acc_q)
        ACC_HI:   rd_byte = pick_byte(cnt_live, 1'b1);
        ACC_WORD: rd_byte = pick_byte(cnt_live, rseq_hi_q);
        default:  rd_byte = pick_byte(cnt_live, 1'b0);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q      <= ACC_WORD;
      mode       <= MODE_RST;
      bcd        <= 1'b0;
      wseq_hi_q  <= 1'b0;
      rseq_hi_q  <= 1'b0;
      low_held_q <= 8'h00;
      sts_pend   <= 1'b0;
      sts_q      <= 8'h00;
      cnt_pend   <= ACC_NONE;
      cnt_snap   <= 16'h0000;
      load_stb   <= 1'b1;
      load_val   <= 16'h0000;
    end else begin
      load_stb <= load_now;
      if (load_now)
        load_val <= compose_count(acc_q, low_held_q, wbyte);

      // read side effects, in precedence order
      if (rd_hit) begin
        if (sts_pend)
          sts_pend <= 1'b0;
        else if (cnt_pend == ACC_WORD)
          cnt_pend <= ACC_HI;
        else if (cnt_pend != ACC_NONE)
          cnt_pend <= ACC_NONE;
        else if (acc_q == ACC_WORD)
          rseq_hi_q <= !rseq_hi_q;
      end

      if (data_we && (acc_q == ACC_WORD)) begin
        wseq_hi_q <= !wseq_hi_q;
        if (!wseq_hi_q)
          low_held_q <= wbyte;
      end

      if (cfg_we) begin
        acc_q     <= cw_acc;
        mode      <= cw_mode;
        bcd       <= cw_bcd;
        wseq_hi_q <= 1'b0;
        rseq_hi_q <= 1'b0;
      end

      if (cnt_frz_req && (cnt_pend == ACC_NONE)) begin
        cnt_pend <= acc_q;
        cnt_snap <= cnt_live;
      end

      if (sts_frz_req && !sts_pend) begin
        sts_pend <= 1'b1;
        sts_q    <= status_byte(out_lvl, acc_q, mode, bcd);
      end
    end
  end

endmodule

// File: rtl/tmr_host_if.sv
module tmr_host_if
  import tmr_host_pkg::*;
#(
  parameter int             NCH      = 3,
  parameter logic [NCH-1:0] GATE_RST = 3'b011
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       addr,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  input  logic [NCH*16-1:0] cnt_live,
  input  logic [NCH-1:0]   out_lvl,
  input  logic [NCH-1:0]   gate_req,
  output logic [NCH-1:0]   load_stb,
  output logic [NCH*16-1:0] load_val,
  output logic [NCH*3-1:0] mode_o,
  output logic [NCH-1:0]   bcd_o,
  output logic [NCH-1:0]   gate_o
);
  localparam int CW = 16;

  logic [NCH-1:0]      cfg_we, data_we, cnt_frz_req, sts_frz_req;
  acc_e                cw_acc;
  logic [2:0]          cw_mode;
  logic                cw_bcd;
  logic [NCH-1:0][7:0] rd_byte;
  logic [NCH-1:0]      sts_pend;
  logic [NCH-1:0]      cnt_busy;
  logic [NCH*CW-1:0]   cnt_snap;
  logic [7:0]          rd_next;

  tmr_ctrl_decode #(.NCH(NCH)) u_dec (
    .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .cfg_we(cfg_we), .data_we(data_we),
    .cnt_frz_req(cnt_frz_req), .sts_frz_req(sts_frz_req),
    .cw_acc(cw_acc), .cw_mode(cw_mode), .cw_bcd(cw_bcd)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    acc_e pend_i;
    tmr_chan_regs u_ch (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we[i]), .cw_acc(cw_acc), .cw_mode(cw_mode), .cw_bcd(cw_bcd),
      .data_we(data_we[i]), .wbyte(wdata),
      .cnt_frz_req(cnt_frz_req[i]), .sts_frz_req(sts_frz_req[i]),
      .rd_hit(rd_en && (addr == 2'(i))),
      .cnt_live(cnt_live[i*CW +: CW]), .out_lvl(out_lvl[i]),
      .rd_byte(rd_byte[i]),
      .load_stb(load_stb[i]), .load_val(load_val[i*CW +: CW]),
      .mode(mode_o[i*3 +: 3]), .bcd(bcd_o[i]),
      .sts_pend(sts_pend[i]), .cnt_pend(pend_i),
      .cnt_snap(cnt_snap[i*CW +: CW])
    );
    assign cnt_busy[i] = (pend_i != ACC_NONE);
  end

  always_comb begin
    rd_next = 8'hFF;
    for (int i = 0; i < NCH; i++)
      if (addr == 2'(i)) rd_next = rd_byte[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= 8'h00;
      gate_o <= GATE_RST;
    end else begin
      gate_o <= gate_req;
      if (rd_en) rdata <= rd_next;
    end
  end

endmodule

// File: rtl/tmr_host_if_chk.sv
module tmr_host_if_chk #(
  parameter int NCH = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       addr,
  input logic             wr_en,
  input logic             rd_en,
  input logic [7:0]       rdata,
  input logic [NCH-1:0]   load_stb,
  input logic [NCH-1:0]   sts_pend,
  input logic [NCH-1:0]   cnt_busy,
  input logic [NCH*16-1:0] cnt_snap
);
  logic first_q;
  always_ff @(posedge clk) begin
    if (!rst_n) first_q <= 1'b1;
    else        first_q <= 1'b0;
  end

  a_r9_ctrl_read_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd3) |=> (rdata == 8'hFF));

  for (genvar i = 0; i < NCH; i++) begin : g_a
    a_r2_load_from_write: assert property (@(posedge clk) disable iff (!rst_n)
      (load_stb[i] && !first_q) |-> $past(wr_en && addr == 2'(i)));
    a_r7_status_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_pend[i] && !(rd_en && addr == 2'(i))) |=> sts_pend[i]);
    a_r7_status_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_pend[i] && rd_en && addr == 2'(i) && !wr_en) |=> !sts_pend[i]);
    a_r5_snapshot_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_busy[i] |=> $stable(cnt_snap[i*16 +: 16]));
  end

endmodule

bind tmr_host_if tmr_host_if_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .rdata(rdata), .load_stb(load_stb), .sts_pend(sts_pend),
  .cnt_busy(cnt_busy), .cnt_snap(cnt_snap)
);

// File: tb/tmr_host_if_tb.sv
module tmr_host_if_tb;
  localparam int NCH = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       addr = '0;
  logic             wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]       wdata = '0;
  logic [7:0]       rdata;
  logic [NCH*16-1:0] cnt_live = '0;
  logic [NCH-1:0]   out_lvl = '0;
  logic [NCH-1:0]   gate_req = 3'b011;
  logic [NCH-1:0]   load_stb;
  logic [NCH*16-1:0] load_val;
  logic [NCH*3-1:0] mode_o;
  logic [NCH-1:0]   bcd_o, gate_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  tmr_host_if #(.NCH(NCH)) u_dut (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  // {req, op(0 read,1 write no load,2 write with load), addr, data, expected}
  localparam int NV = 31;
  localparam logic [31:0] VEC [NV] = '{
    {4'd1, 2'd1, 2'd3, 8'h34, 16'h0000},  // R1 ch0 word, mode 2
    {4'd3, 2'd1, 2'd0, 8'h78, 16'h0000},  // R3 first byte held
    {4'd3, 2'd2, 2'd0, 8'h56, 16'h5678},  // R3 word load
    {4'd8, 2'd0, 2'd0, 8'h00, 16'h0034},  // R8 alternation
    {4'd8, 2'd0, 2'd0, 8'h00, 16'h0012},
    {4'd8, 2'd0, 2'd0, 8'h00, 16'h0034},
    {4'd1, 2'd1, 2'd3, 8'h50, 16'h0000},  // R1 ch1 low only, mode 0
    {4'd2, 2'd2, 2'd1, 8'h9C, 16'h009C},  // R2 low load
    {4'd8, 2'd0, 2'd1, 8'h00, 16'h00CD},
    {4'd8, 2'd0, 2'd1, 8'h00, 16'h00CD},
    {4'd1, 2'd1, 2'd3, 8'hA6, 16'h0000},  // R1 ch2 high only, mode 3
    {4'd2, 2'd2, 2'd2, 8'h07, 16'h0700},  // R2 high load
    {4'd8, 2'd0, 2'd2, 8'h00, 16'h005A},
    {4'd4, 2'd1, 2'd3, 8'h00, 16'h0000},  // R4 freeze ch0
    {4'd4, 2'd0, 2'd0, 8'h00, 16'h0034},
    {4'd4, 2'd0, 2'd0, 8'h00, 16'h0012},
    {4'd8, 2'd0, 2'd0, 8'h00, 16'h0012},
    {4'd6, 2'd1, 2'd3, 8'hCE, 16'h0000},  // R6 read-back all
    {4'd7, 2'd0, 2'd1, 8'h00, 16'h0010},
    {4'd4, 2'd0, 2'd1, 8'h00, 16'h00CD},
    {4'd8, 2'd0, 2'd1, 8'h00, 16'h00CD},
    {4'd7, 2'd0, 2'd2, 8'h00, 16'h00A6},
    {4'd4, 2'd0, 2'd2, 8'h00, 16'h005A},
    {4'd7, 2'd0, 2'd0, 8'h00, 16'h00B4},
    {4'd4, 2'd0, 2'd0, 8'h00, 16'h0034},
    {4'd4, 2'd0, 2'd0, 8'h00, 16'h0012},
    {4'd8, 2'd0, 2'd0, 8'h00, 16'h0034},
    {4'd9, 2'd0, 2'd3, 8'h00, 16'h00FF},  // R9
    {4'd6, 2'd1, 2'd3, 8'hE4, 16'h0000},  // R6 status only ch1
    {4'd6, 2'd0, 2'd1, 8'h00, 16'h0010},
    {4'd6, 2'd0, 2'd1, 8'h00, 16'h00CD}
  };

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    string tag;
    cnt_live = {16'h5A0F, 16'hABCD, 16'h1234};
    out_lvl  = 3'b101;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 load_stb", 16'(load_stb), 16'h0007);
    chk("R10 load_val", load_val[15:0] | load_val[31:16] | load_val[47:32], 16'h0000);
    chk("R10 mode", 16'(mode_o), 16'(9'b011_011_011));
    chk("R10 gate", 16'(gate_o), 16'h0003);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 pulse ends", 16'(load_stb), 16'h0000);
    wr(2'd3, 8'hE2);                   // status of ch0 after reset
    rd(2'd0, d); chk("R10 status", 16'(d), 16'h00B6);

    for (int k = 0; k < NV; k++) begin
      logic [31:0] v;
      v = VEC[k];
      tag = $sformatf("R%0d vec%0d", v[31:28], k);
      if (v[27:26] == 2'd0) begin
        rd(v[25:24], d); chk(tag, 16'(d), v[15:0]);
      end else begin
        wr(v[25:24], v[23:16]);
        if (v[27:26] == 2'd1) chk(tag, 16'(load_stb), 16'h0000);
        else begin
          chk(tag, 16'(load_stb), 16'(1 << v[25:24]));
          chk(tag, load_val[v[25:24]*16 +: 16], v[15:0]);
        end
      end
    end

    // R5: second freeze ignored while first is unread
    cnt_live[31:16] = 16'h1111;
    wr(2'd3, 8'h40);
    cnt_live[31:16] = 16'h2222;
    wr(2'd3, 8'h40);
    rd(2'd1, d); chk("R5 old snapshot", 16'(d), 16'h0011);
    rd(2'd1, d); chk("R5 live after", 16'(d), 16'h0022);

    // R7: status not refrozen while pending
    wr(2'd3, 8'hE8);
    out_lvl[2] = 1'b0;
    wr(2'd3, 8'hE8);
    rd(2'd2, d); chk("R7 first status kept", 16'(d), 16'h00A6);
    rd(2'd2, d); chk("R7 cleared", 16'(d), 16'h005A);

    // R3: configuring word restarts write sequence; R1 mode/bcd
    wr(2'd3, 8'h31);
    chk("R1 bcd", 16'(bcd_o), 16'h0001);
    wr(2'd0, 8'h11);
    wr(2'd3, 8'h30);
    chk("R1 mode", 16'(mode_o[2:0]), 16'h0000);
    chk("R1 mode ch2", 16'(mode_o[8:6]), 16'h0003);
    wr(2'd0, 8'h22); chk("R3 held after restart", 16'(load_stb), 16'h0000);
    wr(2'd0, 8'h33); chk("R3 restarted load", load_val[15:0], 16'h3322);

    // R8: read alternation restarts on configuring word
    rd(2'd0, d); chk("R8 low", 16'(d), 16'h0034);
    wr(2'd3, 8'h30);
    rd(2'd0, d); chk("R8 low again", 16'(d), 16'h0034);

    // R5/R4: freeze during pending high byte is ignored
    wr(2'd3, 8'h00);
    cnt_live[15:0] = 16'hBEEF;
    rd(2'd0, d); chk("R4 snap low", 16'(d), 16'h0034);
    wr(2'd3, 8'h00);
    rd(2'd0, d); chk("R5 snap high kept", 16'(d), 16'h0012);
    // R7: status ahead of count from one read-back
    wr(2'd3, 8'hC2);
    rd(2'd0, d); chk("R7 status first", 16'(d), 16'h00B0);
    rd(2'd0, d); chk("R6 count low", 16'(d), 16'h00EF);
    rd(2'd0, d); chk("R6 count high", 16'(d), 16'h00BE);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule